// File: doc/BRIEF.md
# Key-Protected Pin Function Configuration

This block holds the alternate-function settings for one GPIO port. It presents a small synchronous register bus: an address, write data and a write strobe go in, and combinational read data comes out. The block drives a 2-bit function code for each pin, plus two route enables. The route enables steer the port's clock pin and data pin to an I2C controller.

There are two configuration registers. The function-select register takes any write. It marks which pins leave plain GPIO mode. The mode register is protected. Bit 1 of the mode register chooses I2C over SPI as the alternate function of the two I2C-capable pins. A bus write to the mode register is only held pending, not applied. It is committed only if three bus writes occur back to back in this order:

1. The unlock key 0x07 written to the first key register.
2. The write to the mode register itself.
3. The lock key 0x13 written to the second key register.

Any other bus write breaks the sequence and throws the pending value away. Idle cycles with no write do not break it. Software therefore cannot switch the pins between the serial functions through a single stray write.

Top module: `pincfg_top`

## Requirements
- R1: While reset is low, and after it, both registers hold zero, every pin code is 00 (GPIO) and both route enables are low.
- R2: A write to address 0 (function select) updates that register at the clock edge of the write, and reading address 0 returns it.
- R3: Reads of address 1 (unlock key) and address 3 (lock key) always return zero.
- R4: The mode register (address 2) takes the pending value when three bus writes are consecutive: 0x07 to address 1, the new value to address 2, then 0x13 to address 3. The register changes at the edge of the third write and reads back at address 2.
- R5: A write to address 2 that does not follow a 0x07 write to address 1 leaves the mode register unchanged.
- R6: Any other bus write between the unlock write and the lock write aborts the sequence, whether to address 0 or to an unmapped address. A later 0x13 write to address 3 then leaves the mode register unchanged.
- R7: A wrong value written to either key register returns the sequencer to idle. After that, a correct lock write alone commits nothing.
- R8: Cycles with no bus write between the three sequence writes do not break the sequence.
- R9: Pin i drives code 00 when function-select bit i is 0. When the bit is 1, it drives code 01 (SPI/primary alternate). The exception is pins 1 and 3 while mode bit 1 is 1: they drive code 10 (I2C). Pin i's code sits at pin_func[2i+1:2i], and code 11 never appears.
- R10: scl_route is high exactly when pin 1 drives code 10, and sda_route exactly when pin 3 drives code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_func | output | 16 | 2-bit function code per pin, pin i at bits [2i+1:2i] |
| scl_route | output | 1 | Pin 1 routed to the I2C clock |
| sda_route | output | 1 | Pin 3 routed to the I2C data |

## Verification
Faults in the sequencer are not directly visible, because its state has no readback. They show at the mode readback and at the I2C pin codes in the cycle after the lock write. A sequencer that fails to go idle after an aborting or wrong-key write commits a value one write too late. This shows as a mode change where none is expected. A lost pending value commits the wrong data, and a stuck-armed state lets a bare mode write through. The stimulus therefore places every kind of interrupting write between the unlock and lock writes. It checks the mode readback after each bus write, so any deviation is caught at the write that caused it.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;
  // Function code driven per pin
  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_ALT  = 2'b01,
    FN_I2C  = 2'b10
  } pin_fn_e;

  // Unlock sequencer states
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'b00,
    SEQ_ARMED = 2'b01,
    SEQ_HELD  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/pincfg_keyseq.sv
module pincfg_keyseq
  import pincfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'h07,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              hit_open,
  input  logic              hit_mode,
  input  logic              hit_close,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit,
  output logic [DATA_W-1:0] staged
);
  seq_state_e state_q, state_d;
  logic [DATA_W-1:0] staged_q;
  logic open_ok, close_ok;

  assign open_ok  = hit_open  && (wdata == KEY_OPEN);
  assign close_ok = hit_close && (wdata == KEY_CLOSE);

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      // every write leaves the sequence unless it advances it
      state_d = open_ok ? SEQ_ARMED : SEQ_IDLE;
      if (state_q == SEQ_ARMED && hit_mode) state_d = SEQ_HELD;
    end
  end

  assign commit = wr_en && close_ok && (state_q == SEQ_HELD);
  assign staged = staged_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      staged_q <= '0;
    end else begin
      state_q <= state_d;
      if (wr_en && hit_mode && state_q == SEQ_ARMED) staged_q <= wdata;
    end
  end
endmodule

// File: rtl/pincfg_pinmux.sv
module pincfg_pinmux
  import pincfg_pkg::*;
#(
  parameter int N_PINS  = 8,
  parameter int SCL_PIN = 1,
  parameter int SDA_PIN = 3
) (
  input  logic [N_PINS-1:0]   fsel,
  input  logic                i2c_sel,
  output logic [2*N_PINS-1:0] pin_func,
  output logic                scl_route,
  output logic                sda_route
);
  genvar i;
  generate
    for (i = 0; i < N_PINS; i++) begin : g_pin
      if (i == SCL_PIN || i == SDA_PIN) begin : g_i2c_capable
        assign pin_func[2*i +: 2] = !fsel[i] ? FN_GPIO : (i2c_sel ? FN_I2C : FN_ALT);
      end else begin : g_plain
        assign pin_func[2*i +: 2] = fsel[i] ? FN_ALT : FN_GPIO;
      end
    end
  endgenerate

  assign scl_route = fsel[SCL_PIN] && i2c_sel;
  assign sda_route = fsel[SDA_PIN] && i2c_sel;
endmodule

// File: rtl/pincfg_top.sv
module pincfg_top
  import pincfg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int N_PINS   = 8,
  parameter int SCL_PIN  = 1,
  parameter int SDA_PIN  = 3,
  parameter int I2C_BIT  = 1,
  parameter logic [ADDR_W-1:0] A_FSEL  = 4'd0,
  parameter logic [ADDR_W-1:0] A_OPEN  = 4'd1,
  parameter logic [ADDR_W-1:0] A_MODE  = 4'd2,
  parameter logic [ADDR_W-1:0] A_CLOSE = 4'd3,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'h07,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 8'h13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2*N_PINS-1:0] pin_func,
  output logic                scl_route,
  output logic                sda_route
);
  localparam int FW = (N_PINS < DATA_W) ? N_PINS : DATA_W;

  logic [DATA_W-1:0] fsel_q, mode_q, staged;
  logic              commit;
  logic [N_PINS-1:0] fsel_pins;

  pincfg_keyseq #(
    .DATA_W(DATA_W), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_we),
    .hit_open (bus_addr == A_OPEN),
    .hit_mode (bus_addr == A_MODE),
    .hit_close(bus_addr == A_CLOSE),
    .wdata    (bus_wdata),
    .commit   (commit),
    .staged   (staged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      mode_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_FSEL) fsel_q <= bus_wdata;
      if (commit) mode_q <= staged;
    end
  end

  always_comb begin
    fsel_pins = '0;
    fsel_pins[FW-1:0] = fsel_q[FW-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_FSEL) bus_rdata = fsel_q;
    else if (bus_addr == A_MODE) bus_rdata = mode_q;
  end

  pincfg_pinmux #(
    .N_PINS(N_PINS), .SCL_PIN(SCL_PIN), .SDA_PIN(SDA_PIN)
  ) u_mux (
    .fsel     (fsel_pins),
    .i2c_sel  (mode_q[I2C_BIT]),
    .pin_func (pin_func),
    .scl_route(scl_route),
    .sda_route(sda_route)
  );
endmodule

// File: rtl/pincfg_chk.sv
module pincfg_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int N_PINS  = 8,
  parameter int SCL_PIN = 1,
  parameter int SDA_PIN = 3,
  parameter logic [ADDR_W-1:0] A_FSEL  = 4'd0,
  parameter logic [ADDR_W-1:0] A_OPEN  = 4'd1,
  parameter logic [ADDR_W-1:0] A_CLOSE = 4'd3,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 8'h13
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [2*N_PINS-1:0] pin_func,
  input logic                scl_route,
  input logic                sda_route,
  input logic [DATA_W-1:0]   fsel,
  input logic [DATA_W-1:0]   mode
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pin_func == '0 && !scl_route && !sda_route));

  // R2
  fsel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_we) && $past(bus_addr) == A_FSEL) |-> fsel == $past(bus_wdata));

  // R3
  key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_OPEN || bus_addr == A_CLOSE) |-> bus_rdata == '0);

  // R4
  mode_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> ($past(bus_we) && $past(bus_addr) == A_CLOSE && $past(bus_wdata) == KEY_CLOSE));

  // R9
  no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_func[2*SCL_PIN +: 2] != 2'b11 && pin_func[2*SDA_PIN +: 2] != 2'b11);

  // R10
  route_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_route == (pin_func[2*SCL_PIN +: 2] == 2'b10)) &&
    (sda_route == (pin_func[2*SDA_PIN +: 2] == 2'b10)));
endmodule

bind pincfg_top pincfg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PINS(N_PINS),
  .SCL_PIN(SCL_PIN), .SDA_PIN(SDA_PIN),
  .A_FSEL(A_FSEL), .A_OPEN(A_OPEN), .A_CLOSE(A_CLOSE), .KEY_CLOSE(KEY_CLOSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_func(pin_func),
  .scl_route(scl_route), .sda_route(sda_route), .fsel(fsel_q), .mode(mode_q)
);

// File: tb/tb_pincfg_top.sv
module tb_pincfg_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  // row: {req[3:0], addr[3:0], wdata[7:0], exp_fsel[7:0], exp_mode[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    32'h200A0A00, // R2 function select write
    32'h52020A00, // R5 bare mode write ignored
    32'h41070A00, // R4 unlock
    32'h42020A00, // R4 pending
    32'h43130A02, // R4 lock commits
    32'h61070A02, // R6 unlock
    32'h62000A02, // R6 pending
    32'h600B0B02, // R6 intervening function select write
    32'h63130B02, // R6 lock after abort: no change
    32'h71050B02, // R7 wrong unlock key
    32'h72000B02, // R7
    32'h73130B02, // R7 no commit
    32'h71070B02, // R7 unlock
    32'h72000B02, // R7 pending
    32'h73120B02, // R7 wrong lock key
    32'h73130B02, // R7 late correct lock: no change
    32'h41070B02, // R4 unlock
    32'h42000B02, // R4 pending clear
    32'h43130B00  // R4 commit clear
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [15:0] pin_func;
  logic scl_route, sda_route;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pincfg_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_func(pin_func),
    .scl_route(scl_route), .sda_route(sda_route)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    check("R1 pins in reset", {14'd0, scl_route, sda_route, pin_func}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, v); check("R1 fsel after reset", v, 0);
    rd(4'd2, v); check("R1 mode after reset", v, 0);
    check("R1 pin codes after reset", pin_func, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][27:24], VEC[i][23:16]);
      rd(4'd0, v);
      check($sformatf("R%0d row %0d fsel", VEC[i][31:28], i), v, VEC[i][15:8]);
      rd(4'd2, v);
      check($sformatf("R%0d row %0d mode", VEC[i][31:28], i), v, VEC[i][7:0]);
    end

    // R9 with fsel=0x0B mode=0x00: pins 0,1,3 code 01
    check("R9 spi codes", pin_func, 16'h0045);
    check("R10 routes off", {scl_route, sda_route}, 0);

    // R8 idle cycles inside the sequence
    wr(4'd1, 8'h07); idle(3);
    wr(4'd2, 8'h02); idle(2);
    wr(4'd3, 8'h13);
    rd(4'd2, v); check("R8 commit with gaps", v, 8'h02);
    check("R9 i2c codes", pin_func, 16'h0089);
    check("R10 routes on", {scl_route, sda_route}, 2'b11);

    // R3 key registers read zero even after key writes
    rd(4'd1, v); check("R3 unlock key read", v, 0);
    rd(4'd3, v); check("R3 lock key read", v, 0);

    // R6 unmapped write aborts
    wr(4'd1, 8'h07); wr(4'd2, 8'h00); wr(4'd5, 8'h00); wr(4'd3, 8'h13);
    rd(4'd2, v); check("R6 unmapped write aborts", v, 8'h02);

    // R9 clearing function select returns pins to GPIO
    wr(4'd0, 8'h00);
    check("R9 gpio codes", pin_func, 0);
    check("R10 routes follow fsel", {scl_route, sda_route}, 0);

    // R1 reset mid-run
    wr(4'd0, 8'hFF);
    rst_n = 1'b0; #1;
    check("R1 async reset pins", {14'd0, scl_route, sda_route, pin_func}, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(4'd0, v); check("R1 fsel cleared", v, 0);
    rd(4'd2, v); check("R1 mode cleared", v, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule